// File: doc/BRIEF.md
# System Control Register File

This block is a small memory-mapped control register file for a multi-core processing system. It sits behind a plain 32-bit register bus made of an address, a write strobe, write data and combinational read data. It drives three kinds of output: a one-cycle whole-system reset pulse, a reset line for each processor core, and a clock-stop line for each processor core.

All control registers are write-protected after power-on. Software must first write a key to the unlock register. A second key, written to the lock register, closes the block again. While the block is unlocked, software can do four things: fire a system reset, hold or release each core's reset and clock, record per-core shutdown flags in a reboot status word, and program a RAM timing word. A read-only identification word carries a device code that the integration sets by parameter.

A software system reset puts the core controls, the RAM word and the lock back to their defaults. The reboot status word keeps its contents and is cleared only by the power-on reset input.

Top module: `sysctl_regfile`

## Requirements
- R1: After power-on reset the following hold. The block is locked. Core 0 has reset and clock-stop both low. Every other core has both high. `sys_rst_pulse` is 0. The core register (offset 0x244) reads `0x22` with two cores. Reboot status (0x258) reads 0. The RAM word (0xA1C) reads with each 3-bit field at its reset value.
- R2: While locked, writes to offsets 0x200, 0x244, 0x258 and 0xA1C change no register and raise no reset pulse.
- R3: A write of exactly 0x0000DF0D to offset 0x8 unlocks the block. Any other value written there leaves the lock state as it was.
- R4: A write of exactly 0x0000767B to offset 0x4 locks the block. Any other value written there leaves the lock state as it was.
- R5: An unlocked write to offset 0x200 with bit 0 set drives `sys_rst_pulse` high for exactly the one cycle after the write edge. A write with bit 0 clear raises no pulse. Offset 0x200 always reads 0.
- R6: The edge on which `sys_rst_pulse` is high does three things: it restores the R1 core controls, restores the RAM word, and re-locks the block.
- R7: In the core register at 0x244, bit n is the reset for core n and bit 4+n is the clock-stop for core n. The outputs `core_rst[n]` and `core_stop[n]` take the written bits on the write edge. All other bits read 0.
- R8: In reboot status at 0x258, bit 31-n is the shutdown flag for core n and bits 27:24 are a software status field. These bits are writable and all others read 0. The register survives the R5 system reset and is cleared only by `rst_n`.
- R9: Offset 0x530 reads {REVISION in bits 31:28, zeros, DEVICE_CODE in bits 16:12, MFR_CODE in bits 11:0}. Writes to it have no effect, even when unlocked.
- R10: The RAM word at 0xA1C stores only bits 18:16, 10:8 and 2:0. All other bits read 0.
- R11: `bus_rdata` follows `bus_addr` combinationally. Unmapped offsets, including 0x4 and 0x8, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sys_rst_pulse | output | 1 | One-cycle system reset request |
| core_rst | output | NCORES | Per-core reset, 1 holds the core in reset |
| core_stop | output | NCORES | Per-core clock stop, 1 gates the core clock |

## Verification
The bench keeps two cores and the 12-bit offset width, which puts every flag position at its fixed place. It overrides the device code to 0x07, the manufacturer code to 0x093 and the revision to 3, so that a misplaced or truncated identification field shows up as a wrong word. It also overrides the RAM field reset value to 1, so that the difference between a restored default and the value software programs (2) is visible after a system reset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam logic [31:0] OFF_LOCK    = 32'h004;
  localparam logic [31:0] OFF_UNLOCK  = 32'h008;
  localparam logic [31:0] OFF_SYSRST  = 32'h200;
  localparam logic [31:0] OFF_CORE    = 32'h244;
  localparam logic [31:0] OFF_REBOOT  = 32'h258;
  localparam logic [31:0] OFF_IDENT   = 32'h530;
  localparam logic [31:0] OFF_RAMCTL  = 32'hA1C;

  localparam logic [31:0] KEY_OPEN  = 32'h0000_DF0D;
  localparam logic [31:0] KEY_CLOSE = 32'h0000_767B;

  localparam int CORE_STOP_BASE = 4;

  // writable bits of the reboot status word
  function automatic logic [31:0] reboot_mask(input int ncores);
    logic [31:0] m;
    m = 32'h0F00_0000;
    for (int n = 0; n < ncores; n++) m[31-n] = 1'b1;
    return m;
  endfunction

  // three 3-bit fields of the RAM timing word
  function automatic logic [31:0] ram_word(input logic [2:0] f);
    return (32'(f) << 16) | (32'(f) << 8) | 32'(f);
  endfunction

  function automatic logic [31:0] ident_word(input logic [3:0] rev,
                                              input logic [4:0] dev,
                                              input logic [11:0] mfr);
    return {rev, 11'b0, dev, mfr};
  endfunction

  // core register readback from output vectors
  function automatic logic [31:0] core_word(input logic [3:0] rst_bits,
                                             input logic [3:0] stop_bits);
    return (32'(stop_bits) << CORE_STOP_BASE) | 32'(rst_bits);
  endfunction
endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        hit_open,
  input  logic        hit_close,
  input  logic [31:0] wdata,
  output logic        unlocked
);
  import sysctl_pkg::*;

  logic open_key, close_key;
  assign open_key  = hit_open  && (wdata == KEY_OPEN);
  assign close_key = hit_close && (wdata == KEY_CLOSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         unlocked <= 1'b0;
    else if (soft_rst)  unlocked <= 1'b0;
    else if (open_key)  unlocked <= 1'b1;
    else if (close_key) unlocked <= 1'b0;
  end
endmodule

// File: rtl/sysctl_core_ctrl.sv
module sysctl_core_ctrl #(
  parameter int NCORES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [NCORES-1:0] wr_rst,
  input  logic [NCORES-1:0] wr_stop,
  output logic [NCORES-1:0] core_rst,
  output logic [NCORES-1:0] core_stop
);
  for (genvar n = 0; n < NCORES; n++) begin : g_core
    // core 0 boots running, others parked in reset with clock stopped
    localparam logic PARK = (n != 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        core_rst[n]  <= PARK;
        core_stop[n] <= PARK;
      end else if (soft_rst) begin
        core_rst[n]  <= PARK;
        core_stop[n] <= PARK;
      end else if (wr_en) begin
        core_rst[n]  <= wr_rst[n];
        core_stop[n] <= wr_stop[n];
      end
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int          NCORES        = 2,
  parameter int          ADDR_W        = 12,
  parameter logic [4:0]  DEVICE_CODE   = 5'h1B,
  parameter logic [11:0] MFR_CODE      = 12'h093,
  parameter logic [3:0]  REVISION      = 4'h0,
  parameter logic [2:0]  RAM_FIELD_RST = 3'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_rst_pulse,
  output logic [NCORES-1:0] core_rst,
  output logic [NCORES-1:0] core_stop
);
  import sysctl_pkg::*;

  localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFF_LOCK);
  localparam logic [ADDR_W-1:0] A_UNLOCK = ADDR_W'(OFF_UNLOCK);
  localparam logic [ADDR_W-1:0] A_SYSRST = ADDR_W'(OFF_SYSRST);
  localparam logic [ADDR_W-1:0] A_CORE   = ADDR_W'(OFF_CORE);
  localparam logic [ADDR_W-1:0] A_REBOOT = ADDR_W'(OFF_REBOOT);
  localparam logic [ADDR_W-1:0] A_IDENT  = ADDR_W'(OFF_IDENT);
  localparam logic [ADDR_W-1:0] A_RAMCTL = ADDR_W'(OFF_RAMCTL);

  localparam logic [31:0] REBOOT_MASK = reboot_mask(NCORES);
  localparam logic [31:0] RAM_MASK    = ram_word(3'b111);
  localparam logic [31:0] RAM_RST     = ram_word(RAM_FIELD_RST);
  localparam logic [31:0] IDENT_VAL   = ident_word(REVISION, DEVICE_CODE, MFR_CODE);

  // named internal events
  logic        unlocked;
  logic        soft_rst;
  logic        wr_ok;
  logic        hit_open, hit_close;
  logic        wr_sysrst, wr_core, wr_reboot, wr_ramctl;
  logic [31:0] reboot_q;
  logic [31:0] ramctl_q;
  logic [NCORES-1:0] wr_rst_bits, wr_stop_bits;

  assign hit_open  = bus_we && (bus_addr == A_UNLOCK);
  assign hit_close = bus_we && (bus_addr == A_LOCK);
  assign wr_ok     = bus_we && unlocked;
  assign wr_sysrst = wr_ok && (bus_addr == A_SYSRST);
  assign wr_core   = wr_ok && (bus_addr == A_CORE);
  assign wr_reboot = wr_ok && (bus_addr == A_REBOOT);
  assign wr_ramctl = wr_ok && (bus_addr == A_RAMCTL);
  assign soft_rst  = sys_rst_pulse;

  for (genvar n = 0; n < NCORES; n++) begin : g_wbits
    assign wr_rst_bits[n]  = bus_wdata[n];
    assign wr_stop_bits[n] = bus_wdata[CORE_STOP_BASE + n];
  end

  sysctl_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .hit_open  (hit_open),
    .hit_close (hit_close),
    .wdata     (bus_wdata),
    .unlocked  (unlocked)
  );

  sysctl_core_ctrl #(.NCORES(NCORES)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .wr_en     (wr_core),
    .wr_rst    (wr_rst_bits),
    .wr_stop   (wr_stop_bits),
    .core_rst  (core_rst),
    .core_stop (core_stop)
  );

  // system reset request: one cycle after the accepting write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sys_rst_pulse <= 1'b0;
    else        sys_rst_pulse <= wr_sysrst && bus_wdata[0] && !sys_rst_pulse;
  end

  // reboot status: only power-on reset clears it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reboot_q <= '0;
    else if (wr_reboot) reboot_q <= bus_wdata & REBOOT_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ramctl_q <= RAM_RST;
    else if (soft_rst)  ramctl_q <= RAM_RST;
    else if (wr_ramctl) ramctl_q <= bus_wdata & RAM_MASK;
  end

  logic [3:0] rst_pad, stop_pad;
  assign rst_pad  = 4'(core_rst);
  assign stop_pad = 4'(core_stop);

  always_comb begin
    case (bus_addr)
      A_CORE:   bus_rdata = core_word(rst_pad, stop_pad);
      A_REBOOT: bus_rdata = reboot_q;
      A_IDENT:  bus_rdata = IDENT_VAL;
      A_RAMCTL: bus_rdata = ramctl_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sysctl_checker.sv
module sysctl_checker #(
  parameter int NCORES = 2,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic              sys_rst_pulse,
  input logic [NCORES-1:0] core_rst,
  input logic [NCORES-1:0] core_stop,
  input logic              unlocked,
  input logic [31:0]       reboot_q
);
  import sysctl_pkg::*;

  localparam logic [NCORES-1:0] PARK = ~(NCORES'(1));

  logic sys_wr_go, open_wr, close_wr, core_wr, reboot_wr;
  assign sys_wr_go = bus_we && (bus_addr == ADDR_W'(OFF_SYSRST)) && bus_wdata[0];
  assign open_wr   = bus_we && (bus_addr == ADDR_W'(OFF_UNLOCK)) && (bus_wdata == KEY_OPEN);
  assign close_wr  = bus_we && (bus_addr == ADDR_W'(OFF_LOCK)) && (bus_wdata == KEY_CLOSE);
  assign core_wr   = bus_we && (bus_addr == ADDR_W'(OFF_CORE));
  assign reboot_wr = bus_we && (bus_addr == ADDR_W'(OFF_REBOOT));

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);

  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_pulse) |-> $past(sys_wr_go && unlocked));

  p_locked_core_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && core_wr && !sys_rst_pulse) |=> ($stable(core_rst) && $stable(core_stop)));

  p_soft_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> (core_rst == PARK && core_stop == PARK && !unlocked));

  p_open_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_wr && !sys_rst_pulse) |=> unlocked);

  p_close_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (close_wr && !sys_rst_pulse) |=> !unlocked);

  p_reboot_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_pulse && !reboot_wr) |=> $stable(reboot_q));
endmodule

bind sysctl_regfile sysctl_checker #(.NCORES(NCORES), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_we        (bus_we),
  .bus_wdata     (bus_wdata),
  .sys_rst_pulse (sys_rst_pulse),
  .core_rst      (core_rst),
  .core_stop     (core_stop),
  .unlocked      (unlocked),
  .reboot_q      (reboot_q)
);

// File: tb/tb_sysctl_regfile.sv
`timescale 1ns/1ps
module tb_sysctl_regfile;
  localparam int          NC  = 2;
  localparam int          AW  = 12;
  localparam logic [4:0]  DEV = 5'h07;
  localparam logic [11:0] MFR = 12'h093;
  localparam logic [3:0]  REV = 4'h3;
  localparam logic [2:0]  RFR = 3'd1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          sys_rst_pulse;
  logic [NC-1:0] core_rst, core_stop;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sysctl_regfile #(.NCORES(NC), .ADDR_W(AW), .DEVICE_CODE(DEV), .MFR_CODE(MFR),
                   .REVISION(REV), .RAM_FIELD_RST(RFR)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_pulse(sys_rst_pulse),
    .core_rst(core_rst), .core_stop(core_stop));

  localparam logic [31:0] RAM_DEF = 32'h0001_0101;
  localparam logic [31:0] ID_EXP  = (32'(REV) << 28) | (32'(DEV) << 12) | 32'(MFR);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    bus_addr = AW'(a);
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic por();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 pulse", 32'(sys_rst_pulse), 0);
    check("R1 core_rst", 32'(core_rst), 32'b10);
    check("R1 core_stop", 32'(core_stop), 32'b10);
    rdchk("R1 core reg", 32'h244, 32'h22);
    rdchk("R1 reboot", 32'h258, 0);
    rdchk("R1 ramctl", 32'hA1C, RAM_DEF);
  endtask

  task automatic t_locked();
    wr(32'h244, 32'h0);
    wr(32'hA1C, 32'h0002_0202);
    wr(32'h258, 32'hC000_0000);
    wr(32'h200, 32'h1);
    check("R2 no pulse", 32'(sys_rst_pulse), 0);
    rdchk("R2 core kept", 32'h244, 32'h22);
    rdchk("R2 ram kept", 32'hA1C, RAM_DEF);
    rdchk("R2 reboot kept", 32'h258, 0);
  endtask

  task automatic t_unlock();
    wr(32'h8, 32'h0000_1234);
    wr(32'hA1C, 32'h0002_0202);
    rdchk("R3 wrong key keeps lock", 32'hA1C, RAM_DEF);
    wr(32'h8, 32'h0000_DF0D);
    wr(32'hA1C, 32'hFFFF_FFFF);
    rdchk("R3 unlocked write / R10 mask", 32'hA1C, 32'h0007_0707);
    wr(32'hA1C, 32'h0002_0202);
    rdchk("R10 fields 2", 32'hA1C, 32'h0002_0202);
  endtask

  task automatic t_cores();
    wr(32'h244, 32'h20);
    check("R7 core1 out of reset", 32'(core_rst), 32'b00);
    check("R7 core1 still stopped", 32'(core_stop), 32'b10);
    wr(32'h244, 32'h00);
    check("R7 core1 clock on", 32'(core_stop), 32'b00);
    wr(32'h244, 32'h11);
    check("R7 core0 stop rst", 32'(core_rst), 32'b01);
    check("R7 core0 stop clk", 32'(core_stop), 32'b01);
    wr(32'h244, 32'hFF);
    rdchk("R7 unused bits", 32'h244, 32'h33);
  endtask

  task automatic t_reboot_id();
    wr(32'h258, 32'hFFFF_FFFF);
    rdchk("R8 writable bits", 32'h258, 32'hCF00_0000);
    wr(32'h258, 32'hC000_0000);
    rdchk("R8 clear status field", 32'h258, 32'hC000_0000);
    wr(32'h530, 32'h0);
    rdchk("R9 ident", 32'h530, ID_EXP);
    begin
      logic [31:0] d;
      rd(32'h530, d);
      check("R9 device field", (d >> 12) & 32'h1F, 32'(DEV));
    end
    rdchk("R11 unmapped", 32'h100, 0);
    rdchk("R11 unlock reg reads 0", 32'h8, 0);
    rdchk("R11 lock reg reads 0", 32'h4, 0);
    rdchk("R5 sysrst reg reads 0", 32'h200, 0);
  endtask

  task automatic t_lock();
    wr(32'h4, 32'h0000_1111);
    wr(32'hA1C, 32'h0003_0303);
    rdchk("R4 wrong key stays open", 32'hA1C, 32'h0003_0303);
    wr(32'h4, 32'h0000_767B);
    wr(32'hA1C, 32'h0002_0202);
    rdchk("R4 relocked", 32'hA1C, 32'h0003_0303);
    wr(32'h8, 32'h0000_DF0D);
  endtask

  task automatic t_sysrst();
    wr(32'h200, 32'h0);
    check("R5 bit0 clear no pulse", 32'(sys_rst_pulse), 0);
    wr(32'h244, 32'h11);
    wr(32'h200, 32'h1);
    check("R5 pulse high", 32'(sys_rst_pulse), 1);
    @(negedge clk);
    check("R5 pulse one cycle", 32'(sys_rst_pulse), 0);
    check("R6 core_rst default", 32'(core_rst), 32'b10);
    check("R6 core_stop default", 32'(core_stop), 32'b10);
    rdchk("R6 ram default", 32'hA1C, RAM_DEF);
    rdchk("R8 reboot survives", 32'h258, 32'hC000_0000);
    wr(32'hA1C, 32'h0002_0202);
    rdchk("R6 relocked", 32'hA1C, RAM_DEF);
    por();
    rdchk("R8 cleared by power-on", 32'h258, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_unlock();
    t_cores();
    t_reboot_id();
    t_lock();
    t_sysrst();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule